// File: doc/BRIEF.md
# Bus-Master DMA Control Registers

This block holds the control and status registers that sit beside a SCSI protocol core and steer its bus-master data engine. Software programs a starting byte count, a starting memory address and a starting descriptor address, then issues a start command; the block copies those values into working registers and raises the DMA enable line. Software can also issue idle, flush and abort commands. A flush or an abort is passed to the data engine as a one-cycle pulse.

As the data engine moves bytes, it offers each transfer on a valid/ready channel. The block limits each transfer to the remaining working count and refuses a transfer whose direction does not match the programmed one. It reports the granted length one cycle later, decrements the working count and advances the working address. When the SCSI core signals that a command has finished, the working count is forced to zero and the done flag is set.

The status register reports power-down, error, abort, done, SCSI-interrupt and burst-complete flags. A separate bus-control register selects how the flags are cleared: either by writing ones, or by reading the register.

Top module: `dma_ctl_regs`

## Requirements
- R1: After reset, the command reads 0x0, the working count reads 0x0, the working address reads 0xFFFFFFFF, the working descriptor address reads 0xFFFFFFFD and the status reads 0x0. `dma_enable` and `dma_irq` are low.
- R2: Register addresses are 0 command, 1 starting count, 2 starting address, 3 working count, 4 working address, 5 status, 6 starting descriptor address, 7 working descriptor address, and 8 bus-control. Addresses 0, 1, 2, 6 and 8 read back the last value written. Writes to addresses 3, 4 and 7 are ignored.
- R3: A command write with bits 1:0 = 3 (start) copies the starting count, address and descriptor address into their working registers. It clears status bits 5:0 and sets `dma_enable` from the next cycle on.
- R4: Command bits 1:0 = 0 (idle) clear `dma_enable`. Bits 1:0 = 1 (flush) pulse `flush_req` high for one cycle, and bits 1:0 = 2 (abort) pulse `abort_req` high for one cycle; neither flush nor abort changes `dma_enable`.
- R5: A transfer is accepted when `xfer_valid` and `xfer_ready` are both high. If `xfer_dir` equals command bit 7 (1 = device to memory), the granted length is the smaller of `xfer_len` and the working count. The next cycle, `xfer_rsp_valid` is high and `xfer_rsp_len` holds the granted length; by then the working count has dropped by that length and the working address has risen by it.
- R6: A transfer whose `xfer_dir` differs from command bit 7 is granted length 0 and leaves the working count and working address unchanged.
- R7: While `cmd_complete` is high, `xfer_ready` is low. On the next cycle the working count is 0 and status bit 3 (done) is set.
- R8: A status read returns bit 4 set whenever `scsi_irq` is high, in addition to the stored flags.
- R9: With bus-control bit 12 clear, a status write clears status bits 1, 2 and 3 wherever the written value has a one. Other bits are unaffected.
- R10: With bus-control bit 12 set, status writes are ignored, and a status read returns the flags and then clears bits 1, 2 and 3.
- R11: `dma_irq` is high exactly when status bit 3 (done) and command bit 6 are both set.
- R12: The data for a read is presented on `reg_rdata` with `reg_rvalid` high in the cycle after `reg_rd_en`. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd_en |
| xfer_valid | input | 1 | Data engine offers a transfer |
| xfer_ready | output | 1 | Block can accept a transfer this cycle |
| xfer_dir | input | 1 | Transfer direction, 1 = device to memory |
| xfer_len | input | 16 | Requested byte count |
| xfer_rsp_valid | output | 1 | Granted length valid |
| xfer_rsp_len | output | 16 | Granted byte count |
| scsi_irq | input | 1 | SCSI core interrupt pending |
| cmd_complete | input | 1 | SCSI command finished (one-cycle pulse) |
| dma_enable | output | 1 | DMA engine enabled |
| flush_req | output | 1 | Burst-flush request pulse |
| abort_req | output | 1 | Abort request pulse |
| dma_irq | output | 1 | DMA interrupt request |

## Verification
The assertions assume the following about the inputs:
- A register read and a register write are never issued in the same cycle.
- `cmd_complete` is a single-cycle pulse.
- The data engine holds no transfer pending across a completion, because `xfer_ready` drops during it.
- The response channel has no back-pressure, so each accepted transfer yields exactly one response on the next cycle.

The stimulus drives one register access or one transfer at a time on falling edges. It raises `xfer_valid` only in cycles with no start command or completion pending, so every handshake it makes is accepted and produces a response the scoreboard expects.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  localparam int unsigned IDX_CMD   = 0;
  localparam int unsigned IDX_SCNT  = 1;
  localparam int unsigned IDX_SADDR = 2;
  localparam int unsigned IDX_WCNT  = 3;
  localparam int unsigned IDX_WADDR = 4;
  localparam int unsigned IDX_STAT  = 5;
  localparam int unsigned IDX_SDESC = 6;
  localparam int unsigned IDX_WDESC = 7;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_FLUSH = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } dma_op_e;

  localparam int unsigned STAT_W    = 6;
  localparam int unsigned ST_ERR    = 1;
  localparam int unsigned ST_ABT    = 2;
  localparam int unsigned ST_DONE   = 3;
  localparam int unsigned ST_SINT   = 4;
  localparam logic [STAT_W-1:0] CLEARABLE_MASK = 6'b00_1110;

  localparam int unsigned CMD_DIR_BIT    = 7;
  localparam int unsigned CMD_IRQEN_BIT  = 6;
  localparam int unsigned BC_COR_BIT     = 12;

  localparam logic [31:0] WADDR_RST = 32'hFFFF_FFFF;
  localparam logic [31:0] WDESC_RST = 32'hFFFF_FFFD;
endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
  import dma_ctl_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          start_hit,
  output logic          idle_hit,
  output logic          flush_req,
  output logic          abort_req
);
  logic    cmd_wr;
  dma_op_e op;

  assign cmd_wr = wr_en && (addr == AW'(IDX_CMD));
  assign op     = dma_op_e'(wdata[1:0]);

  assign start_hit = cmd_wr && (op == OP_START);
  assign idle_hit  = cmd_wr && (op == OP_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_req <= 1'b0;
      abort_req <= 1'b0;
    end else begin
      flush_req <= cmd_wr && (op == OP_FLUSH);
      abort_req <= cmd_wr && (op == OP_ABORT);
    end
  end
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_ctl_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DW-1:0]    start_cnt,
  input  logic [DW-1:0]    start_addr,
  input  logic             complete,
  input  logic             cmd_dir,
  input  logic             xfer_valid,
  input  logic             xfer_dir,
  input  logic [LEN_W-1:0] xfer_len,
  output logic             xfer_ready,
  output logic [DW-1:0]    wcnt_q,
  output logic [DW-1:0]    waddr_q,
  output logic             rsp_valid,
  output logic [LEN_W-1:0] rsp_len
);
  localparam int unsigned PAD_W = DW - LEN_W;

  logic             take;
  logic             dir_ok;
  logic [DW-1:0]    len_ext;
  logic [DW-1:0]    clip;
  logic [DW-1:0]    moved;

  assign xfer_ready = !start && !complete;
  assign take       = xfer_valid && xfer_ready;
  assign dir_ok     = (xfer_dir == cmd_dir);
  assign len_ext    = {{PAD_W{1'b0}}, xfer_len};
  assign clip       = (len_ext < wcnt_q) ? len_ext : wcnt_q;
  assign moved      = dir_ok ? clip : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q  <= '0;
      waddr_q <= WADDR_RST[DW-1:0];
    end else if (complete) begin
      wcnt_q  <= '0;
    end else if (start) begin
      wcnt_q  <= start_cnt;
      waddr_q <= start_addr;
    end else if (take) begin
      wcnt_q  <= wcnt_q - moved;
      waddr_q <= waddr_q + moved;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_len   <= '0;
    end else begin
      rsp_valid <= take;
      if (take) rsp_len <= moved[LEN_W-1:0];
    end
  end
endmodule

// File: rtl/dma_status_unit.sv
module dma_status_unit
  import dma_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              done_set,
  input  logic              stat_wr,
  input  logic              stat_rd,
  input  logic              clr_on_read,
  input  logic [STAT_W-1:0] wbits,
  input  logic              scsi_irq,
  output logic [STAT_W-1:0] status_q,
  output logic [STAT_W-1:0] status_view
);
  logic [STAT_W-1:0] nxt;

  always_comb begin
    nxt = status_q;
    if (stat_wr && !clr_on_read) nxt = nxt & ~(wbits & CLEARABLE_MASK);
    if (stat_rd && clr_on_read)  nxt = nxt & ~CLEARABLE_MASK;
    if (start)                   nxt = '0;
    if (done_set)                nxt[ST_DONE] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= nxt;
  end

  always_comb begin
    status_view          = status_q;
    status_view[ST_SINT] = status_q[ST_SINT] | scsi_irq;
  end
endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
  import dma_ctl_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned AW     = 4,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned BC_IDX = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic             reg_rd_en,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             reg_rvalid,
  input  logic             xfer_valid,
  output logic             xfer_ready,
  input  logic             xfer_dir,
  input  logic [LEN_W-1:0] xfer_len,
  output logic             xfer_rsp_valid,
  output logic [LEN_W-1:0] xfer_rsp_len,
  input  logic             scsi_irq,
  input  logic             cmd_complete,
  output logic             dma_enable,
  output logic             flush_req,
  output logic             abort_req,
  output logic             dma_irq
);
  localparam int unsigned NSTART = 3;
  localparam int unsigned START_IDX [NSTART] = '{IDX_SCNT, IDX_SADDR, IDX_SDESC};

  logic [DW-1:0]     cmd_q;
  logic [DW-1:0]     bc_q;
  logic [DW-1:0]     wdesc_q;
  logic [DW-1:0]     start_q [NSTART];
  logic [DW-1:0]     wcnt_q;
  logic [DW-1:0]     waddr_q;
  logic [STAT_W-1:0] status_q;
  logic [STAT_W-1:0] status_view;
  logic              start_hit;
  logic              idle_hit;
  logic              stat_wr;
  logic              stat_rd;
  logic [DW-1:0]     rd_mux;

  dma_cmd_decode #(.AW(AW), .DW(DW)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .start_hit (start_hit),
    .idle_hit  (idle_hit),
    .flush_req (flush_req),
    .abort_req (abort_req)
  );

  for (genvar g = 0; g < NSTART; g++) begin : g_start
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) start_q[g] <= '0;
      else if (reg_wr_en && reg_addr == AW'(START_IDX[g])) start_q[g] <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= '0;
      bc_q       <= '0;
      wdesc_q    <= WDESC_RST[DW-1:0];
      dma_enable <= 1'b0;
    end else begin
      if (reg_wr_en && reg_addr == AW'(IDX_CMD)) cmd_q <= reg_wdata;
      if (reg_wr_en && reg_addr == AW'(BC_IDX))  bc_q  <= reg_wdata;
      if (start_hit) begin
        wdesc_q    <= start_q[2];
        dma_enable <= 1'b1;
      end else if (idle_hit) begin
        dma_enable <= 1'b0;
      end
    end
  end

  dma_xfer_engine #(.DW(DW), .LEN_W(LEN_W)) u_xfer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_hit),
    .start_cnt  (start_q[0]),
    .start_addr (start_q[1]),
    .complete   (cmd_complete),
    .cmd_dir    (cmd_q[CMD_DIR_BIT]),
    .xfer_valid (xfer_valid),
    .xfer_dir   (xfer_dir),
    .xfer_len   (xfer_len),
    .xfer_ready (xfer_ready),
    .wcnt_q     (wcnt_q),
    .waddr_q    (waddr_q),
    .rsp_valid  (xfer_rsp_valid),
    .rsp_len    (xfer_rsp_len)
  );

  assign stat_wr = reg_wr_en && reg_addr == AW'(IDX_STAT);
  assign stat_rd = reg_rd_en && reg_addr == AW'(IDX_STAT);

  dma_status_unit u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start_hit),
    .done_set    (cmd_complete),
    .stat_wr     (stat_wr),
    .stat_rd     (stat_rd),
    .clr_on_read (bc_q[BC_COR_BIT]),
    .wbits       (reg_wdata[STAT_W-1:0]),
    .scsi_irq    (scsi_irq),
    .status_q    (status_q),
    .status_view (status_view)
  );

  assign dma_irq = status_q[ST_DONE] && cmd_q[CMD_IRQEN_BIT];

  always_comb begin
    rd_mux = '0;
    if (reg_addr == AW'(BC_IDX)) rd_mux = bc_q;
    else begin
      case (reg_addr)
        AW'(IDX_CMD):   rd_mux = cmd_q;
        AW'(IDX_SCNT):  rd_mux = start_q[0];
        AW'(IDX_SADDR): rd_mux = start_q[1];
        AW'(IDX_WCNT):  rd_mux = wcnt_q;
        AW'(IDX_WADDR): rd_mux = waddr_q;
        AW'(IDX_STAT):  rd_mux = {{(DW-STAT_W){1'b0}}, status_view};
        AW'(IDX_SDESC): rd_mux = start_q[2];
        AW'(IDX_WDESC): rd_mux = wdesc_q;
        default:        rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd_en;
      if (reg_rd_en) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/dma_ctl_regs_checker.sv
module dma_ctl_regs_checker #(
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 4,
  parameter int unsigned LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr_en,
  input logic [AW-1:0]    reg_addr,
  input logic [DW-1:0]    reg_wdata,
  input logic             xfer_valid,
  input logic             xfer_ready,
  input logic             xfer_dir,
  input logic [DW-1:0]    cmd_q,
  input logic [DW-1:0]    wcnt_q,
  input logic [5:0]       status_q,
  input logic             xfer_rsp_valid,
  input logic [LEN_W-1:0] xfer_rsp_len,
  input logic             dma_enable,
  input logic             abort_req,
  input logic             cmd_complete
);
  logic cmd_wr;
  assign cmd_wr = reg_wr_en && reg_addr == '0;

  AST_START_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && reg_wdata[1:0] == 2'd3 |=> dma_enable);  // R3
  AST_IDLE_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && reg_wdata[1:0] == 2'd0 |=> !dma_enable);  // R4
  AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_req) |-> $past(cmd_wr && reg_wdata[1:0] == 2'd2));  // R4
  AST_HANDSHAKE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && xfer_ready |=> xfer_rsp_valid);  // R5
  AST_COUNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && xfer_ready |=> wcnt_q <= $past(wcnt_q));  // R5
  AST_MISDIR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && xfer_ready && xfer_dir != cmd_q[7] |=> xfer_rsp_len == '0);  // R6
  AST_CMPL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_complete |-> !xfer_ready);  // R7
  AST_CMPL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_complete |=> status_q[3] && wcnt_q == '0);  // R7
endmodule

bind dma_ctl_regs dma_ctl_regs_checker #(.DW(DW), .AW(AW), .LEN_W(LEN_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .reg_wr_en      (reg_wr_en),
  .reg_addr       (reg_addr),
  .reg_wdata      (reg_wdata),
  .xfer_valid     (xfer_valid),
  .xfer_ready     (xfer_ready),
  .xfer_dir       (xfer_dir),
  .cmd_q          (cmd_q),
  .wcnt_q         (wcnt_q),
  .status_q       (status_q),
  .xfer_rsp_valid (xfer_rsp_valid),
  .xfer_rsp_len   (xfer_rsp_len),
  .dma_enable     (dma_enable),
  .abort_req      (abort_req),
  .cmd_complete   (cmd_complete)
);

// File: tb/dma_ctl_regs_bench.sv
module dma_ctl_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        xfer_valid = 1'b0, xfer_dir = 1'b0;
  logic        xfer_ready;
  logic [15:0] xfer_len = '0;
  logic        xfer_rsp_valid;
  logic [15:0] xfer_rsp_len;
  logic        scsi_irq = 1'b0, cmd_complete = 1'b0;
  logic        dma_enable, flush_req, abort_req, dma_irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [31:0] rd_exp_q [$];
  string       rd_tag_q [$];
  logic [15:0] rsp_exp_q [$];
  string       rsp_tag_q [$];

  always #2 clk = ~clk;

  dma_ctl_regs u_dma_ctl_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_dir(xfer_dir),
    .xfer_len(xfer_len), .xfer_rsp_valid(xfer_rsp_valid), .xfer_rsp_len(xfer_rsp_len),
    .scsi_irq(scsi_irq), .cmd_complete(cmd_complete), .dma_enable(dma_enable),
    .flush_req(flush_req), .abort_req(abort_req), .dma_irq(dma_irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      if (rd_exp_q.size() == 0) chk("R12 unexpected read data", 32'h1, 32'h0);
      else chk(rd_tag_q.pop_front(), reg_rdata, rd_exp_q.pop_front());
    end
    if (rst_n && xfer_rsp_valid) begin
      if (rsp_exp_q.size() == 0) chk("R5 unexpected response", 32'h1, 32'h0);
      else chk(rsp_tag_q.pop_front(), {16'h0, xfer_rsp_len}, {16'h0, rsp_exp_q.pop_front()});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_exp_q.push_back(exp); rd_tag_q.push_back(tag);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
  endtask

  task automatic xfer(input logic d, input logic [15:0] n, input logic [15:0] exp, input string tag);
    @(negedge clk);
    rsp_exp_q.push_back(exp); rsp_tag_q.push_back(tag);
    xfer_valid = 1'b1; xfer_dir = d; xfer_len = n;
    @(negedge clk);
    xfer_valid = 1'b0;
  endtask

  task automatic complete();
    @(negedge clk);
    cmd_complete = 1'b1;
    #1 chk("R7 ready low during completion", {31'h0, xfer_ready}, 32'h0);
    @(negedge clk);
    cmd_complete = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 dma_enable", {31'h0, dma_enable}, 32'h0);
    chk("R1 dma_irq", {31'h0, dma_irq}, 32'h0);
    rd(4'd0, 32'h0, "R1 command");
    rd(4'd3, 32'h0, "R1 working count");
    rd(4'd4, 32'hFFFF_FFFF, "R1 working address");
    rd(4'd7, 32'hFFFF_FFFD, "R1 working descriptor");
    rd(4'd5, 32'h0, "R1 status");
    // R2 readback and ignored writes
    wr(4'd1, 32'd100); wr(4'd2, 32'h0000_1000); wr(4'd6, 32'h0000_ABC0); wr(4'd8, 32'h0);
    wr(4'd3, 32'h55); wr(4'd4, 32'h1234); wr(4'd7, 32'h4321);
    rd(4'd1, 32'd100, "R2 starting count");
    rd(4'd2, 32'h1000, "R2 starting address");
    rd(4'd6, 32'hABC0, "R2 starting descriptor");
    rd(4'd3, 32'h0, "R2 working count write ignored");
    rd(4'd4, 32'hFFFF_FFFF, "R2 working address write ignored");
    rd(4'd7, 32'hFFFF_FFFD, "R2 working descriptor write ignored");
    rd(4'd9, 32'h0, "R12 unmapped address");
    // R3 start, dir = memory to device, irq enable
    wr(4'd0, 32'h43);
    chk("R3 dma_enable after start", {31'h0, dma_enable}, 32'h1);
    rd(4'd0, 32'h43, "R2 command readback");
    rd(4'd3, 32'd100, "R3 working count loaded");
    rd(4'd4, 32'h1000, "R3 working address loaded");
    rd(4'd7, 32'hABC0, "R3 working descriptor loaded");
    // R5 / R6 transfers
    xfer(1'b0, 16'd30, 16'd30, "R5 full grant");
    rd(4'd3, 32'd70, "R5 count decremented");
    rd(4'd4, 32'h101E, "R5 address advanced");
    xfer(1'b1, 16'd5, 16'd0, "R6 wrong direction grant");
    rd(4'd3, 32'd70, "R6 count unchanged");
    rd(4'd4, 32'h101E, "R6 address unchanged");
    xfer(1'b0, 16'd90, 16'd70, "R5 clipped grant");
    rd(4'd3, 32'd0, "R5 count exhausted");
    rd(4'd4, 32'h1064, "R5 address after clip");
    // R7 completion after a fresh start
    wr(4'd0, 32'h43);
    rd(4'd3, 32'd100, "R3 restart reloads count");
    complete();
    rd(4'd3, 32'd0, "R7 count forced to zero");
    rd(4'd5, 32'h08, "R7 done set");
    chk("R11 irq with done and enable", {31'h0, dma_irq}, 32'h1);
    // R8 live scsi interrupt
    scsi_irq = 1'b1;
    rd(4'd5, 32'h18, "R8 scsi interrupt ORed");
    scsi_irq = 1'b0;
    // R9 write-one-to-clear
    wr(4'd5, 32'h04);
    rd(4'd5, 32'h08, "R9 other bits kept");
    wr(4'd5, 32'h08);
    rd(4'd5, 32'h00, "R9 done cleared");
    chk("R11 irq low without done", {31'h0, dma_irq}, 32'h0);
    // R10 clear-on-read
    complete();
    wr(4'd8, 32'h0000_1000);
    rd(4'd8, 32'h0000_1000, "R2 bus-control readback");
    wr(4'd5, 32'h08);
    rd(4'd5, 32'h08, "R10 write ignored, read returns");
    rd(4'd5, 32'h00, "R10 cleared by read");
    // R4 commands
    wr(4'd0, 32'h42);
    chk("R4 abort pulse", {31'h0, abort_req}, 32'h1);
    @(negedge clk);
    chk("R4 abort pulse ends", {31'h0, abort_req}, 32'h0);
    chk("R4 abort keeps enable", {31'h0, dma_enable}, 32'h1);
    wr(4'd0, 32'h41);
    chk("R4 flush pulse", {31'h0, flush_req}, 32'h1);
    @(negedge clk);
    chk("R4 flush pulse ends", {31'h0, flush_req}, 32'h0);
    chk("R4 flush keeps enable", {31'h0, dma_enable}, 32'h1);
    complete();
    chk("R11 irq on done", {31'h0, dma_irq}, 32'h1);
    wr(4'd0, 32'h00);
    chk("R4 idle drops enable", {31'h0, dma_enable}, 32'h0);
    chk("R11 irq off when enable bit clear", {31'h0, dma_irq}, 32'h0);
    repeat (3) @(negedge clk);
    chk("R12 all reads answered", rd_exp_q.size(), 32'h0);
    chk("R5 all responses seen", rsp_exp_q.size(), 32'h0);
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule